// File: doc/BRIEF.md
# Nine-bit SPI panel command engine

This block talks to an LCD panel over a three-wire style serial link in which every word is nine bits long. The top bit of each word tells the panel whether the remaining eight bits are a command opcode (bit 8 clear) or a parameter byte (bit 8 set). The block builds the three transaction shapes the panel understands: a lone command, a command followed by parameter words, and a command followed by read data. Chip select stays low across the whole transaction.

On top of the link sits a small sequencer that runs the panel's fixed power scripts. A power-on request reads the three-byte panel identity and checks the first byte. If the byte is accepted, the sequencer wakes the panel and waits for it to settle, then loads the init and pixel-format settings and turns the display on. A power-off request turns the display off and puts the panel to sleep, followed by a settle wait. Waits are counted in milliseconds from a clock prescaler parameter, so a test can shorten them without changing the script.

Top module: `panel_cmd_engine`

## Requirements
- R1: The link works in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and the block samples MISO on the rising SCLK edge. Words go out MSB first.
- R2: A command word is nine bits with bit 8 = 0 and the opcode in bits 7:0. A parameter word is nine bits with bit 8 = 1 and the byte in bits 7:0.
- R3: CS (active low) falls before the first SCLK rise of a transaction and stays low until the last clock of it. CS is high and SCLK is low whenever the block is not busy.
- R4: The identity read sends command 0x004 and then issues 25 clocks: 8 for byte 0, one extra clock, then 8 each for bytes 1 and 2, which makes 34 clocks in all. `panel_id` then holds {byte0, byte1, byte2}.
- R5: Identity byte 0 of 0x45 or 0x83 is accepted. Any other value sets `id_error`, ends the sequence right after the read with `busy` low and `panel_active` low, and sends nothing more. `id_error` clears when the next power-on request is accepted.
- R6: The power-on transactions are, in order: [0x004 + read], [0x011], [0x0C2, 0x102, 0x100, 0x100], [0x03A, pixel-format word], [0x029]. After the last one, `panel_active` goes to 1. The pixel-format word is 0x150, 0x160 or 0x170 for 16, 18 or 24 data lines; the default is 24.
- R7: After the wake command 0x011, CS stays high for 120 ms (120 x CLKS_PER_MS cycles, plus at most 10 cycles) before the next transaction starts.
- R8: The power-off transactions are [0x028] then [0x010]. After the second one, `busy` stays high for a 50 ms wait (plus at most 10 cycles) and then `panel_active` clears.
- R9: A power-on request while active, a power-off request while inactive, and any request while busy are ignored. None of them produces CS or SCLK activity or changes the script.
- R10: After reset, CS is high, SCLK and MOSI are low, and `busy`, `panel_active` and `id_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | One-cycle request to run the power-on script |
| pwr_off_req | input | 1 | One-cycle request to run the power-off script |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_miso | input | 1 | Serial data from the panel |
| spi_cs_n | output | 1 | Panel select, active low |
| busy | output | 1 | A script is running |
| panel_active | output | 1 | Power-on script completed and panel not yet powered off |
| id_error | output | 1 | Last identity read returned an unaccepted first byte |
| panel_id | output | 24 | Identity bytes from the last read, byte 0 in the top byte |

## Verification
The assertions check the link rules on every cycle. MOSI must hold while SCLK is high, SCLK may only pulse inside a CS-low window, and the lines must be idle whenever the block is not busy. They also check that an identity error never coexists with an active panel and always leaves the block idle, and that the active flag only drops once the off script has finished. The bench scenarios are what show the content and timing. They show the exact word order of both scripts and the bit-8 marking. They show where the extra read clock sits, which the returned identity bytes reveal. They measure the millisecond settle gaps and show that misplaced requests are dropped.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_SHIFT,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic       is_wait;
        logic [8:0] word;
        logic       read_id;
        logic       close_cs;
        logic       last;
        logic [7:0] wait_ms;
    } step_t;

    localparam int WORD_BITS   = 9;
    localparam int IDX_W       = 4;
    localparam int RD_SEGS     = 4;   // byte0, extra clock, byte1, byte2
    localparam int RD_SEG_W    = 2;

    localparam logic [IDX_W-1:0] ON_START  = 4'd0;
    localparam logic [IDX_W-1:0] OFF_START = 4'd10;

    localparam logic [7:0] OP_GET_ID   = 8'h04;
    localparam logic [7:0] OP_WAKE     = 8'h11;
    localparam logic [7:0] OP_NAP      = 8'h10;
    localparam logic [7:0] OP_SHOW     = 8'h29;
    localparam logic [7:0] OP_HIDE     = 8'h28;
    localparam logic [7:0] OP_INIT     = 8'hC2;
    localparam logic [7:0] OP_PIXFMT   = 8'h3A;

    function automatic logic [8:0] cmd_word(input logic [7:0] op);
        return {1'b0, op};
    endfunction

    function automatic logic [8:0] par_word(input logic [7:0] b);
        return {1'b1, b};
    endfunction

    function automatic logic [7:0] pix_byte(input int lines);
        case (lines)
            16:      return 8'h50;
            18:      return 8'h60;
            default: return 8'h70;
        endcase
    endfunction

    function automatic logic id_accepted(input logic [7:0] b);
        return (b == 8'h45) || (b == 8'h83);
    endfunction

    function automatic logic [3:0] rd_seg_bits(input logic [RD_SEG_W-1:0] seg);
        return (seg == 2'd1) ? 4'd1 : 4'd8;
    endfunction

    function automatic step_t send_step(input logic [8:0] w, input logic close,
                                        input logic fin);
        step_t s;
        s.is_wait  = 1'b0;
        s.word     = w;
        s.read_id  = 1'b0;
        s.close_cs = close;
        s.last     = fin;
        s.wait_ms  = 8'd0;
        return s;
    endfunction

    function automatic step_t wait_step(input logic [7:0] ms, input logic fin);
        step_t s;
        s.is_wait  = 1'b1;
        s.word     = 9'd0;
        s.read_id  = 1'b0;
        s.close_cs = 1'b0;
        s.last     = fin;
        s.wait_ms  = ms;
        return s;
    endfunction

    // Power-on occupies indices 0..9, power-off 10..12.
    function automatic step_t script_step(input logic [IDX_W-1:0] idx,
                                          input logic [7:0] pix,
                                          input logic [7:0] wake_ms,
                                          input logic [7:0] nap_ms);
        step_t s;
        case (idx)
            4'd0: begin
                s = send_step(cmd_word(OP_GET_ID), 1'b1, 1'b0);
                s.read_id = 1'b1;
            end
            4'd1:    s = send_step(cmd_word(OP_WAKE), 1'b1, 1'b0);
            4'd2:    s = wait_step(wake_ms, 1'b0);
            4'd3:    s = send_step(cmd_word(OP_INIT), 1'b0, 1'b0);
            4'd4:    s = send_step(par_word(8'h02), 1'b0, 1'b0);
            4'd5:    s = send_step(par_word(8'h00), 1'b0, 1'b0);
            4'd6:    s = send_step(par_word(8'h00), 1'b1, 1'b0);
            4'd7:    s = send_step(cmd_word(OP_PIXFMT), 1'b0, 1'b0);
            4'd8:    s = send_step(par_word(pix), 1'b1, 1'b0);
            4'd9:    s = send_step(cmd_word(OP_SHOW), 1'b1, 1'b1);
            4'd10:   s = send_step(cmd_word(OP_HIDE), 1'b1, 1'b0);
            4'd11:   s = send_step(cmd_word(OP_NAP), 1'b1, 1'b0);
            4'd12:   s = wait_step(nap_ms, 1'b1);
            default: s = wait_step(8'd1, 1'b1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/spi9_shifter.sv
module spi9_shifter
    import panel_seq_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [3:0]           nbits,
    input  logic [WORD_BITS-1:0] tx,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 done,
    output logic [7:0]           rx
);
    localparam int HC_W = $clog2(SCLK_HALF) + 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCLK_HALF - 1);

    logic                 active;
    logic                 high;
    logic [HC_W-1:0]      hcnt;
    logic [3:0]           left;
    logic [WORD_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            high   <= 1'b0;
            hcnt   <= '0;
            left   <= '0;
            sh     <= '0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    high   <= 1'b0;
                    hcnt   <= '0;
                    left   <= nbits;
                    sh     <= tx;
                end
            end else if (hcnt == HC_LAST) begin
                hcnt <= '0;
                if (!high) begin
                    high <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    high <= 1'b0;
                    sh   <= {sh[WORD_BITS-2:0], 1'b0};
                    if (left == 4'd1) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        left <= left - 4'd1;
                    end
                end
            end else begin
                hcnt <= hcnt + HC_W'(1);
            end
        end
    end

    assign sclk = high;
    assign mosi = active & sh[WORD_BITS-1];

endmodule

// File: rtl/ms_timer.sv
module ms_timer #(
    parameter int CLKS_PER_MS = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] ms,
    output logic       expired
);
    localparam int PW = $clog2(CLKS_PER_MS) + 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_MS - 1);

    logic          running;
    logic [PW-1:0] pre;
    logic [7:0]    ms_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            pre     <= '0;
            ms_left <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                running <= 1'b1;
                pre     <= '0;
                ms_left <= ms;
            end else if (running) begin
                if (pre == PRE_LAST) begin
                    pre <= '0;
                    if (ms_left <= 8'd1) begin
                        running <= 1'b0;
                        expired <= 1'b1;
                    end else begin
                        ms_left <= ms_left - 8'd1;
                    end
                end else begin
                    pre <= pre + PW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/panel_cmd_engine.sv
module panel_cmd_engine
    import panel_seq_pkg::*;
#(
    parameter int CLKS_PER_MS  = 100000,
    parameter int SCLK_HALF    = 4,
    parameter int PIX_LINES    = 24,
    parameter int WAKE_MS      = 120,
    parameter int NAP_MS       = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_on_req,
    input  logic        pwr_off_req,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        busy,
    output logic        panel_active,
    output logic        id_error,
    output logic [23:0] panel_id
);
    localparam logic [7:0] PIX = pix_byte(PIX_LINES);
    localparam logic [7:0] WAKE_W = 8'(WAKE_MS);
    localparam logic [7:0] NAP_W  = 8'(NAP_MS);
    localparam logic [RD_SEG_W-1:0] RD_LAST = RD_SEG_W'(RD_SEGS - 1);

    seq_state_e            state;
    logic [IDX_W-1:0]      idx;
    logic [RD_SEG_W-1:0]   rd_seg;
    logic                  in_read;
    logic                  on_seq;
    logic                  cs_q;
    logic                  active_q;
    logic                  err_q;
    logic [23:0]           id_q;
    step_t                 cur;

    logic                  sh_start;
    logic [3:0]            sh_nbits;
    logic [WORD_BITS-1:0]  sh_tx;
    logic                  sh_done;
    logic [7:0]            sh_rx;
    logic                  tm_load;
    logic                  tm_expired;

    assign cur = script_step(idx, PIX, WAKE_W, NAP_W);

    always_comb begin
        sh_start = 1'b0;
        sh_nbits = 4'(WORD_BITS);
        sh_tx    = cur.word;
        tm_load  = 1'b0;
        case (state)
            ST_ISSUE: begin
                if (cur.is_wait) tm_load = 1'b1;
                else             sh_start = 1'b1;
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    if (!in_read && cur.read_id) begin
                        sh_start = 1'b1;
                        sh_nbits = rd_seg_bits('0);
                        sh_tx    = '0;
                    end else if (in_read && rd_seg != RD_LAST) begin
                        sh_start = 1'b1;
                        sh_nbits = rd_seg_bits(rd_seg + RD_SEG_W'(1));
                        sh_tx    = '0;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            rd_seg   <= '0;
            in_read  <= 1'b0;
            on_seq   <= 1'b0;
            cs_q     <= 1'b1;
            active_q <= 1'b0;
            err_q    <= 1'b0;
            id_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pwr_on_req && !active_q) begin
                        state  <= ST_ISSUE;
                        idx    <= ON_START;
                        on_seq <= 1'b1;
                        err_q  <= 1'b0;
                    end else if (pwr_off_req && active_q) begin
                        state  <= ST_ISSUE;
                        idx    <= OFF_START;
                        on_seq <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    if (cur.is_wait) begin
                        state <= ST_WAIT;
                    end else begin
                        cs_q    <= 1'b0;
                        in_read <= 1'b0;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (!in_read && cur.read_id) begin
                            in_read <= 1'b1;
                            rd_seg  <= '0;
                        end else if (in_read) begin
                            if (rd_seg != 2'd1) id_q <= {id_q[15:0], sh_rx};
                            if (rd_seg == RD_LAST) begin
                                cs_q    <= 1'b1;
                                in_read <= 1'b0;
                                if (!id_accepted(id_q[15:8])) begin
                                    err_q <= 1'b1;
                                    state <= ST_IDLE;
                                end else begin
                                    idx   <= idx + IDX_W'(1);
                                    state <= ST_ISSUE;
                                end
                            end else begin
                                rd_seg <= rd_seg + RD_SEG_W'(1);
                            end
                        end else begin
                            if (cur.close_cs) cs_q <= 1'b1;
                            if (cur.last) begin
                                active_q <= on_seq;
                                state    <= ST_IDLE;
                            end else begin
                                idx   <= idx + IDX_W'(1);
                                state <= ST_ISSUE;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (tm_expired) begin
                        if (cur.last) begin
                            active_q <= on_seq;
                            state    <= ST_IDLE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    spi9_shifter #(.SCLK_HALF(SCLK_HALF)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .nbits (sh_nbits),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    ms_timer #(.CLKS_PER_MS(CLKS_PER_MS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tm_load),
        .ms      (cur.wait_ms),
        .expired (tm_expired)
    );

    assign spi_cs_n     = cs_q;
    assign busy         = (state != ST_IDLE);
    assign panel_active = active_q;
    assign id_error     = err_q;
    assign panel_id     = id_q;

endmodule

// File: rtl/panel_cmd_engine_chk.sv
module panel_cmd_engine_chk (
    input logic clk,
    input logic rst,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic busy,
    input logic panel_active,
    input logic id_error
);
    p_idle_lines_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_cs_n && !spi_sclk));

    p_clock_inside_select_r3: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);

    p_mosi_hold_high_r1: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_err_not_active_r5: assert property (@(posedge clk) disable iff (rst)
        id_error |-> !panel_active);

    p_err_leaves_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(id_error) |-> !busy);

    p_off_after_script_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(panel_active) |-> !busy);

endmodule

bind panel_cmd_engine panel_cmd_engine_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_cs_n     (spi_cs_n),
    .busy         (busy),
    .panel_active (panel_active),
    .id_error     (id_error)
);

// File: tb/sim_panel_cmd_engine.sv
module sim_panel_cmd_engine;
    localparam int CPMS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_on_req = 1'b0;
    logic        pwr_off_req = 1'b0;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic        spi_cs_n;
    logic        busy;
    logic        panel_active;
    logic        id_error;
    logic [23:0] panel_id;

    always #2 clk = ~clk;

    panel_cmd_engine #(.CLKS_PER_MS(CPMS), .SCLK_HALF(2)) u0 (
        .clk(clk), .rst(rst), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .busy(busy), .panel_active(panel_active),
        .id_error(id_error), .panel_id(panel_id)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int mode_viol = 0;

    // panel model state
    logic [8:0]  wlog [64];
    int          wcnt = 0;
    int          tbits [16];
    int          tfall [16];
    int          trise [16];
    int          tcnt = 0;
    int          nb = 0;
    int          nf = 0;
    logic        rd_mode = 1'b0;
    logic [8:0]  sv = '0;
    logic [24:0] resp = '0;
    logic [7:0]  id0 = 8'h45, id1 = 8'h9A, id2 = 8'h3C;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge spi_cs_n) begin
        nb = 0; nf = 0; rd_mode = 1'b0;
        if (tcnt < 16) tfall[tcnt] = cyc;
    end

    always @(posedge spi_cs_n) begin
        if (tcnt < 16) begin
            tbits[tcnt] = nb;
            trise[tcnt] = cyc;
        end
        tcnt = tcnt + 1;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            sv = {sv[7:0], spi_mosi};
            nb = nb + 1;
            if (!rd_mode && (nb % 9 == 0)) begin
                if (wcnt < 64) wlog[wcnt] = sv;
                wcnt = wcnt + 1;
                if (nb == 9 && sv == 9'h004) rd_mode = 1'b1;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            nf = nf + 1;
            if (rd_mode) begin
                if (nf == 9) resp = {id0, 1'b0, id1, id2};
                else         resp = resp << 1;
                spi_miso = resp[24];
            end
        end
    end

    // mode-0 observation: MOSI must not move while SCLK stays high; no clock outside CS
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_sclk && spi_sclk && (spi_mosi !== prev_mosi)) mode_viol++;
            if (spi_sclk && spi_cs_n) mode_viol++;
        end
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wcnt = 0; tcnt = 0; spi_miso = 1'b0;
    endtask

    task automatic pulse(input logic on);
        @(negedge clk);
        if (on) pwr_on_req = 1'b1; else pwr_off_req = 1'b1;
        @(negedge clk);
        pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, req, busy, 0);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0, "R10 lines",
              {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        check(busy === 1'b0 && panel_active === 1'b0 && id_error === 1'b0, "R10 flags",
              {busy, panel_active, id_error}, 0);
    endtask

    task automatic t_off_while_idle();
        clear_log();
        pulse(1'b0);
        repeat (40) @(negedge clk);
        check(tcnt == 0 && busy == 1'b0, "R9 off ignored when inactive", tcnt, 0);
    endtask

    task automatic t_power_on_good(input logic [7:0] first);
        logic [8:0] exp_w [9] = '{9'h004, 9'h011, 9'h0C2, 9'h102, 9'h100, 9'h100,
                                   9'h03A, 9'h170, 9'h029};
        int exp_b [5] = '{34, 9, 36, 18, 9};
        int gap;
        clear_log();
        id0 = first; id1 = 8'h9A; id2 = 8'h3C;
        pulse(1'b1);
        check(busy == 1'b1, "R9 on accepted", busy, 1);
        // requests while busy must be dropped (R9)
        repeat (300) @(negedge clk);
        pulse(1'b1);
        pulse(1'b0);
        wait_idle("R6 on completes");
        check(tcnt == 5, "R6 transaction count", tcnt, 5);
        check(wcnt == 9, "R6 word count", wcnt, 9);
        for (int i = 0; i < 9; i++)
            if (i < wcnt) check(wlog[i] == exp_w[i], "R2 R6 word", wlog[i], exp_w[i]);
        for (int i = 0; i < 5; i++)
            if (i < tcnt) check(tbits[i] == exp_b[i], "R3 R4 clocks per transaction",
                                tbits[i], exp_b[i]);
        check(panel_id == {first, 8'h9A, 8'h3C}, "R4 R1 identity bytes", panel_id,
              {first, 8'h9A, 8'h3C});
        gap = tfall[2] - trise[1];
        check(gap >= 120 * CPMS && gap <= 120 * CPMS + 10, "R7 wake settle gap", gap, 120 * CPMS);
        check(panel_active == 1'b1 && id_error == 1'b0, "R6 active after on",
              {panel_active, id_error}, 2'b10);
        check(mode_viol == 0, "R1 mode0 MOSI/CS rules", mode_viol, 0);
    endtask

    task automatic t_on_while_active();
        clear_log();
        pulse(1'b1);
        repeat (40) @(negedge clk);
        check(tcnt == 0 && busy == 1'b0 && panel_active == 1'b1, "R9 on ignored when active",
              tcnt, 0);
    endtask

    task automatic t_power_off();
        int t0;
        int n = 0;
        clear_log();
        pulse(1'b0);
        while (tcnt < 2 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        t0 = cyc;
        check(busy == 1'b1 && panel_active == 1'b1, "R8 still busy after sleep-in",
              {busy, panel_active}, 2'b11);
        wait_idle("R8 off completes");
        check(cyc - t0 >= 50 * CPMS && cyc - t0 <= 50 * CPMS + 10, "R8 sleep-in wait",
              cyc - t0, 50 * CPMS);
        check(wcnt == 2 && wlog[0] == 9'h028 && wlog[1] == 9'h010, "R8 R2 off words",
              {wlog[0], wlog[1]}, {9'h028, 9'h010});
        check(tcnt == 2, "R3 off transactions", tcnt, 2);
        check(panel_active == 1'b0, "R8 inactive after off", panel_active, 0);
    endtask

    task automatic t_power_on_bad();
        clear_log();
        id0 = 8'h12; id1 = 8'h34; id2 = 8'h56;
        pulse(1'b1);
        wait_idle("R5 bad id stops");
        check(id_error == 1'b1 && panel_active == 1'b0, "R5 error flags",
              {id_error, panel_active}, 2'b10);
        check(tcnt == 1 && wcnt == 1, "R5 nothing after read", tcnt, 1);
        check(panel_id == 24'h123456, "R4 identity on error", panel_id, 24'h123456);
        repeat (100) @(negedge clk);
        check(tcnt == 1 && busy == 1'b0, "R5 stays idle", tcnt, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_off_while_idle();
        t_power_on_good(8'h45);
        t_on_while_active();
        t_power_off();
        t_power_on_bad();
        t_power_on_good(8'h83);   // also shows R5 error cleared by a new request
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule